// File: doc/BRIEF.md
# Transmit Byte Tagger for an HDLC Sender

This block sits between a processor's register writes and the transmit FIFO of an HDLC sender. The processor writes a data byte, and the block turns it into a FIFO word that carries the byte and two tags. One tag marks the end of a packet. The other asks the serializer to abort the frame in place of that byte.

The processor can set the tags in two ways. The first is to set one-shot request bits in a control register before writing the byte. Those bits clear themselves once the byte has been accepted. The second is to program a packet length into a down-counter, which then tags the last byte of each packet on its own. With the repeat bit set, the counter reloads after each tagged byte, so a stream of packets of the same length needs no further setup. A byte written while the FIFO reports full is discarded, and a sticky overflow flag records the loss.

Top module: `txtag_front`

## Requirements
- R1: After reset, `push` and `ovf_flag` are 0, both tag requests and the repeat bit are clear, and the counter is 0, so automatic tagging is off.
- R2: A write to address 2 while `fifo_full` is 0 is accepted. On the next clock cycle `push` is 1 for exactly one cycle, and `push_word[7:0]` holds the written byte.
- R3: A write to address 0 sets three bits. Bit 0 requests end of packet, bit 1 requests frame abort, and bit 2 is the repeat bit. The next accepted byte carries the end-of-packet request in `push_word[8]` and the frame-abort request in `push_word[9]`.
- R4: Both tag requests clear themselves when a byte is accepted, so the byte after a tagged byte is untagged. The repeat bit keeps its value.
- R5: A write to address 1 loads the packet length into both the length register and the counter. Each accepted byte lowers a nonzero counter by one. The byte accepted while the counter is 1 has `push_word[8]` set.
- R6: When the counter tags a byte, it reloads from the length register if the repeat bit is 1, and drops to 0 if the repeat bit is 0.
- R7: While the counter is 0, no byte is tagged automatically. Only the request bits set the tags.
- R8: When a request bit and the counter both mark the same byte, the end-of-packet tag is the OR of the two. Any frame-abort request is also carried in the same word.
- R9: A write to address 2 while `fifo_full` is 1 produces no push. It leaves the tag requests and the counter unchanged, and sets `ovf_flag`, which stays 1 until reset.
- R10: A write to address 3 has no effect on any output or on the tagging state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 length, 2 data, 3 unused |
| wr_data | input | DW | Write data |
| fifo_full | input | 1 | Transmit FIFO cannot take a word |
| push | output | 1 | FIFO push strobe |
| push_word | output | DW+2 | {abort tag, end tag, data byte} |
| ovf_flag | output | 1 | Sticky flag for a dropped byte |

## Verification
Every result arrives through exactly one register. The push, its word, and the overflow flag all belong to the write presented at the previous clock edge. Control and length writes only change the word of a later data write. The bench drives each vector just after a falling edge and checks the outputs at the next falling edge, which comes half a period after the edge that registered them. Each vector's expected values therefore describe that vector's own write.

// File: rtl/txtag_front.sv
module txtag_front #(
  parameter int DW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          fifo_full,
  output logic          push,
  output logic [DW+1:0] push_word,
  output logic          ovf_flag
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic          eop_req, fa_req, cyc;
  logic [CW-1:0] len, cnt;

  wire wr_ctl   = wr_en && (wr_addr == 2'd0);
  wire wr_len   = wr_en && (wr_addr == 2'd1);
  wire wr_dat   = wr_en && (wr_addr == 2'd2);
  wire take     = wr_dat && !fifo_full;
  wire auto_eop = (cnt == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      push      <= 1'b0;
      push_word <= '0;
      ovf_flag  <= 1'b0;
      eop_req   <= 1'b0;
      fa_req    <= 1'b0;
      cyc       <= 1'b0;
      len       <= '0;
      cnt       <= '0;
    end else begin
      push <= take;
      if (take)
        push_word <= {fa_req, eop_req | auto_eop, wr_data};
      if (wr_dat && fifo_full)
        ovf_flag <= 1'b1;

      if (wr_ctl) begin
        eop_req <= wr_data[0];
        fa_req  <= wr_data[1];
        cyc     <= wr_data[2];
      end else if (take) begin
        eop_req <= 1'b0;
        fa_req  <= 1'b0;
      end

      if (wr_len) begin
        len <= wr_data[CW-1:0];
        cnt <= wr_data[CW-1:0];
      end else if (take && cnt != '0) begin
        cnt <= auto_eop ? (cyc ? len : '0) : cnt - ONE;
      end
    end
  end
endmodule

module txtag_front_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [1:0]    wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          fifo_full,
  input logic          push,
  input logic [DW+1:0] push_word,
  input logic          ovf_flag
);
  // R2
  accept_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd2 && !fifo_full) |=> (push && push_word[DW-1:0] == $past(wr_data)));

  // R2
  push_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && wr_addr == 2'd2 && !fifo_full)) |=> !push);

  // R9
  drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd2 && fifo_full) |=> ovf_flag);

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag);

  // R10
  idle_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd3) |=> (!push && $stable(push_word)));
endmodule

bind txtag_front txtag_front_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .fifo_full(fifo_full), .push(push),
  .push_word(push_word), .ovf_flag(ovf_flag)
);

// File: tb/test_txtag_front.sv
module test_txtag_front;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 30;

  // {wr_en, addr, data, full, exp_push, exp_word, exp_ovf}
  localparam logic [23:0] VEC [NV] = '{
    {1'b1, 2'd0, 8'h00, 1'b0, 1'b0, 10'h000, 1'b0}, // ctl clear
    {1'b1, 2'd2, 8'hAA, 1'b0, 1'b1, 10'h0AA, 1'b0}, // R2 plain
    {1'b1, 2'd0, 8'h01, 1'b0, 1'b0, 10'h000, 1'b0}, // R3 eop req
    {1'b1, 2'd2, 8'h03, 1'b0, 1'b1, 10'h103, 1'b0}, // R3 eop
    {1'b1, 2'd2, 8'h77, 1'b0, 1'b1, 10'h077, 1'b0}, // R4 one-shot
    {1'b1, 2'd0, 8'h02, 1'b0, 1'b0, 10'h000, 1'b0}, // R3 fa req
    {1'b1, 2'd2, 8'h55, 1'b0, 1'b1, 10'h255, 1'b0}, // R3 fa
    {1'b1, 2'd1, 8'h03, 1'b0, 1'b0, 10'h000, 1'b0}, // R5 len 3
    {1'b1, 2'd2, 8'h11, 1'b0, 1'b1, 10'h011, 1'b0}, // R5
    {1'b1, 2'd2, 8'h22, 1'b0, 1'b1, 10'h022, 1'b0}, // R5
    {1'b1, 2'd2, 8'h33, 1'b0, 1'b1, 10'h133, 1'b0}, // R5 auto
    {1'b1, 2'd2, 8'h44, 1'b0, 1'b1, 10'h044, 1'b0}, // R6 R7 no reload
    {1'b1, 2'd0, 8'h04, 1'b0, 1'b0, 10'h000, 1'b0}, // repeat on
    {1'b1, 2'd1, 8'h02, 1'b0, 1'b0, 10'h000, 1'b0}, // len 2
    {1'b1, 2'd2, 8'h01, 1'b0, 1'b1, 10'h001, 1'b0},
    {1'b1, 2'd2, 8'h02, 1'b0, 1'b1, 10'h102, 1'b0}, // R6
    {1'b1, 2'd2, 8'h03, 1'b0, 1'b1, 10'h003, 1'b0}, // R6 reloaded
    {1'b1, 2'd2, 8'h04, 1'b0, 1'b1, 10'h104, 1'b0}, // R6
    {1'b1, 2'd0, 8'h05, 1'b0, 1'b0, 10'h000, 1'b0},
    {1'b1, 2'd2, 8'h05, 1'b0, 1'b1, 10'h105, 1'b0}, // R3 explicit at cnt 2
    {1'b1, 2'd2, 8'h06, 1'b0, 1'b1, 10'h106, 1'b0}, // R5 auto
    {1'b1, 2'd2, 8'h07, 1'b0, 1'b1, 10'h007, 1'b0},
    {1'b1, 2'd0, 8'h05, 1'b0, 1'b0, 10'h000, 1'b0},
    {1'b1, 2'd2, 8'h08, 1'b0, 1'b1, 10'h108, 1'b0}, // R8 both
    {1'b1, 2'd3, 8'hFF, 1'b0, 1'b0, 10'h000, 1'b0}, // R10
    {1'b1, 2'd2, 8'h09, 1'b0, 1'b1, 10'h009, 1'b0}, // R10 state intact
    {1'b1, 2'd0, 8'h06, 1'b0, 1'b0, 10'h000, 1'b0},
    {1'b1, 2'd2, 8'h0A, 1'b1, 1'b0, 10'h000, 1'b1}, // R9 dropped
    {1'b1, 2'd2, 8'h0B, 1'b0, 1'b1, 10'h30B, 1'b1}, // R9 R8 state kept
    {1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 10'h000, 1'b1}  // R9 sticky
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       fifo_full = 1'b0;
  logic       push;
  logic [9:0] push_word;
  logic       ovf_flag;
  int total = 0;
  int bad = 0;

  txtag_front i_txtag_front (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .fifo_full(fifo_full), .push(push),
    .push_word(push_word), .ovf_flag(ovf_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic en, input logic [1:0] a, input logic [7:0] d, input logic f);
    wr_en = en; wr_addr = a; wr_data = d; fifo_full = f;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 push", 32'(push), 32'd0);
    check("R1 ovf", 32'(ovf_flag), 32'd0);
    rst_n = 1'b1;
    step(1'b1, 2'd2, 8'h5A, 1'b0);
    check("R1 untagged", 32'(push_word), 32'h05A);

    for (int i = 0; i < NV; i++) begin
      logic [23:0] v;
      v = VEC[i];
      step(v[23], v[22:21], v[20:13], v[12]);
      check($sformatf("R2 push v%0d", i), 32'(push), 32'(v[11]));
      if (v[11]) check($sformatf("R3 word v%0d", i), 32'(push_word), 32'(v[10:1]));
      check($sformatf("R9 ovf v%0d", i), 32'(ovf_flag), 32'(v[0]));
    end

    step(1'b1, 2'd0, 8'h03, 1'b0);
    step(1'b1, 2'd1, 8'h01, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset push", 32'(push), 32'd0);
    check("R1 reset ovf", 32'(ovf_flag), 32'd0);
    rst_n = 1'b1;
    step(1'b1, 2'd2, 8'hC3, 1'b0);
    check("R1 R7 no tags after reset", 32'(push_word), 32'h0C3);
    step(1'b0, 2'd0, 8'h00, 1'b0);
    check("R2 single-cycle push", 32'(push), 32'd0);

    step(1'b1, 2'd0, 8'h01, 1'b0);
    step(1'b1, 2'd2, 8'h10, 1'b1);
    check("R9 no push when full", 32'(push), 32'd0);
    step(1'b1, 2'd2, 8'h11, 1'b0);
    check("R9 request kept across drop", 32'(push_word), 32'h111);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule